// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable, single-clock model of a pipelined burst SRAM. The word is 36 bits wide and is split into four 9-bit byte lanes. Each cycle the block samples one command, formed from three chip selects, two address strobes and an advance input. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write inputs. When both strobes are idle, the advance input steps the burst to its next address or holds it at the current one, which inserts a wait state. A burst covers four words. A small sequencer produces the addresses within the burst, in interleaved order by default or in linear order when a parameter selects it.

Read data goes through two registers. The address stage captures the read address, and the data stage captures the array word. The word therefore appears on the data-out bus after the second rising edge. The drive flag tells the board-level bus when to drive it. The flag combines the registered read-valid bit with the output enable, which acts without a clock. Writes take their data in the same cycle as the command, with a separate enable for each lane. A write cycle turns the drive off.

Top module: `psram_core`

## Requirements
- R1: A strobed cycle acts on the array only when cs1_n=0, cs2_n=0 and cs2=1. Any other select combination with a strobe low is a deselect: nothing is written, and the burst ends.
- R2: While cs1_n=1, adsp_n is ignored. A cycle with adsp_n=0, adsc_n=1 and cs1_n=1 behaves as a cycle with both strobes idle, so adv_n=0 continues the burst.
- R3: A selected cycle with adsp_n=0 starts a burst at `addr` as a read, whatever gw_n, bwe_n and bw_n are. A write to that address is done by a following hold cycle (adv_n=1) with the write condition true.
- R4: A selected cycle with adsp_n=1 and adsc_n=0 starts a burst at `addr`. It is a write when the write condition holds and a read otherwise.
- R5: The write condition is gw_n=0, or bwe_n=0 together with at least one bw_n bit at 0. With bwe_n=0 and bw_n=4'b1111 the cycle is a read.
- R6: bw_n[0] enables data bits 8:0, bw_n[1] bits 17:9, bw_n[2] bits 26:18 and bw_n[3] bits 35:27. Any subset of lanes can be written in one cycle, and lanes not enabled keep their contents. gw_n=0 writes all four lanes.
- R7: With both strobes idle and a burst open, adv_n=1 repeats the current burst address. A read burst then outputs the same word again.
- R8: With both strobes idle and a burst open, adv_n=0 moves to the next burst address. With INTERLEAVE=1, the low two bits are the start address's low bits XOR a 2-bit count 1, 2, 3, then 0, and the upper bits stay fixed.
- R9: A read sampled at edge k sets dq_drive after edge k+1, with the word on `dout`. dq_drive equals the registered read-valid bit AND NOT oe_n, and oe_n acts without a clock.
- R10: After a deselect sampled at edge k, dq_drive is low from edge k+1 onward until a new read.
- R11: A write sampled at edge k forces dq_drive low after edge k, whatever oe_n is. A hold cycle in a write burst without a write keeps the drive off. Only a strobe or an advance cycle can start a new read.
- R12: While rst is high, the pipeline and burst state are cleared and dq_drive is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| addr | input | ADDR_W | External word address |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Primary chip select, active low |
| cs2_n | input | 1 | Secondary chip select, active low |
| cs2 | input | 1 | Secondary chip select, active high |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dq_drive | output | 1 | High when the data bus is to be driven |

## Verification
The assertions assume that every input except oe_n is stable around the rising edge. They also assume that each written word is written before it is read, because the array is not reset and never-written words read as unknown. The bench changes every input on the falling edge. It keeps a model array, and it reads back only addresses that an earlier cycle wrote. oe_n is also changed only on the falling edge, so the sampled drive flag reflects a settled enable.

// File: rtl/psram_pkg.sv
package psram_pkg;
  // Command decoded from one sampled clock edge.
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,  // no strobe, no open burst
    OP_DESEL = 3'd1,  // strobed but not selected: end burst
    OP_START = 3'd2,  // new burst from the external address
    OP_ADV   = 3'd3,  // next burst address
    OP_HOLD  = 3'd4   // repeat current burst address (wait state)
  } op_e;
endpackage

// File: rtl/psram_decode.sv
module psram_decode
  import psram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             cs1_n,
  input  logic             cs2_n,
  input  logic             cs2,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             active,
  output op_e              op,
  output logic             is_wr,
  output logic [LANES-1:0] lane_en,
  output logic             sel_w,
  output logic             proc_start_w
);
  // Write request: global write, or byte-write enable with any lane low.
  function automatic logic write_req(input logic g_n, input logic b_n,
                                     input logic [LANES-1:0] lanes_n);
    return !g_n || (!b_n && (lanes_n != {LANES{1'b1}}));
  endfunction

  function automatic logic [LANES-1:0] lane_select(input logic g_n, input logic b_n,
                                                   input logic [LANES-1:0] lanes_n);
    if (!g_n)      return {LANES{1'b1}};
    else if (!b_n) return ~lanes_n;
    else           return '0;
  endfunction

  logic proc_strobe;
  logic wr_cond;

  assign sel_w       = !cs1_n && !cs2_n && cs2;
  assign proc_strobe = !adsp_n && !cs1_n;   // processor strobe gated by cs1_n
  assign wr_cond     = write_req(gw_n, bwe_n, bw_n);
  assign lane_en     = lane_select(gw_n, bwe_n, bw_n);

  always_comb begin
    op = OP_IDLE;
    if (proc_strobe || !adsc_n) op = sel_w ? OP_START : OP_DESEL;
    else if (active)            op = adv_n ? OP_HOLD : OP_ADV;
  end

  assign proc_start_w = proc_strobe && sel_w;
  assign is_wr = wr_cond && !proc_start_w &&
                 (op == OP_START || op == OP_ADV || op == OP_HOLD);

  // R3
  proc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && !cs1_n) |-> !is_wr);
  // R1
  unsel_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_w && (!adsc_n || !adsp_n)) |-> !is_wr);
endmodule

// File: rtl/psram_burst_seq.sv
module psram_burst_seq
  import psram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BURST_BITS = 2,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              active,
  output logic              mode_wr,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] cnt_q;
  logic [BURST_BITS-1:0] cnt_nxt;

  // Address of burst step cnt relative to the start address.
  function automatic logic [ADDR_W-1:0] seq_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [BURST_BITS-1:0] cnt);
    logic [BURST_BITS-1:0] low;
    if (INTERLEAVE) low = base[BURST_BITS-1:0] ^ cnt;
    else            low = base[BURST_BITS-1:0] + cnt;
    return {base[ADDR_W-1 -: HI_W], low};
  endfunction

  assign cnt_nxt = cnt_q + 1'b1;

  always_comb begin
    case (op)
      OP_START: eff_addr = ext_addr;
      OP_ADV:   eff_addr = seq_addr(base_q, cnt_nxt);
      default:  eff_addr = seq_addr(base_q, cnt_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      mode_wr <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (op)
        OP_DESEL: active <= 1'b0;
        OP_START: begin
          active  <= 1'b1;
          base_q  <= ext_addr;
          cnt_q   <= '0;
          mode_wr <= is_wr;
        end
        OP_ADV: begin
          cnt_q   <= cnt_nxt;
          mode_wr <= is_wr;
        end
        OP_HOLD: if (is_wr) mode_wr <= 1'b1;
        default: ;
      endcase
    end
  end

  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/psram_store.sv
module psram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we && lane_en[l]) lane_mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)     lane_q <= '0;
      else if (re) lane_q <= lane_mem[raddr];
    end

    assign rdata[l*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/psram_core.sv
module psram_core
  import psram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    cs1_n,
  input  logic                    cs2_n,
  input  logic                    cs2,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dq_drive
);
  op_e               op;
  logic              is_wr;
  logic [LANES-1:0]  lane_en;
  logic              sel_w;
  logic              proc_start_w;
  logic              active;
  logic              mode_wr;
  logic [ADDR_W-1:0] eff_addr;

  // Named pipeline events for the checks.
  logic              rd_issue;
  logic              rd_vld1;
  logic [ADDR_W-1:0] rd_addr1;
  logic              q_vld;

  psram_decode #(.LANES(LANES)) u_dec (
    .clk(clk), .rst(rst), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .cs1_n(cs1_n), .cs2_n(cs2_n), .cs2(cs2), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .active(active), .op(op), .is_wr(is_wr), .lane_en(lane_en),
    .sel_w(sel_w), .proc_start_w(proc_start_w)
  );

  psram_burst_seq #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS), .INTERLEAVE(INTERLEAVE)) u_seq (
    .clk(clk), .rst(rst), .op(op), .is_wr(is_wr), .ext_addr(addr),
    .active(active), .mode_wr(mode_wr), .eff_addr(eff_addr)
  );

  psram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst(rst), .we(is_wr), .waddr(eff_addr), .lane_en(lane_en),
    .wdata(din), .re(rd_vld1), .raddr(rd_addr1), .rdata(dout)
  );

  // A hold in a write burst is a wait state and does not read.
  assign rd_issue = !is_wr &&
                    (op == OP_START || op == OP_ADV || (op == OP_HOLD && !mode_wr));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld1  <= 1'b0;
      rd_addr1 <= '0;
      q_vld    <= 1'b0;
    end else begin
      rd_vld1  <= rd_issue;
      rd_addr1 <= eff_addr;
      q_vld    <= rd_vld1 && !is_wr;   // a sampled write silences the bus
    end
  end

  assign dq_drive = q_vld && !oe_n;

  // R10
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DESEL) |=> ##1 (!q_vld || $past(rd_issue)));
  // R11
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    is_wr |=> !q_vld);
  // R9
  pipe_order_chk: assert property (@(posedge clk) disable iff (rst)
    q_vld |-> $past(rd_vld1));
  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!q_vld && !rd_vld1 && !active));
  // R3
  proc_open_chk: assert property (@(posedge clk) disable iff (rst)
    proc_start_w |=> (rd_vld1 && active && !mode_wr));
endmodule

// File: tb/psram_core_test.sv
module psram_core_test;
  localparam int AW = 6;
  localparam int W  = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic          cs1_n = 1'b1, cs2_n = 1'b1, cs2 = 1'b0;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic          oe_n = 1'b1;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout;
  logic          dq_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psram_core uut (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs2(cs2), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .din(din), .dout(dout),
    .dq_drive(dq_drive)
  );

  // Bench model state.
  logic [W-1:0]  m_mem [64];
  bit            m_act = 0, m_mwr = 0, m_pv = 0;
  logic [AW-1:0] m_base = '0, m_pa = '0;
  logic [1:0]    m_cnt = '0;

  // Scoreboard queues: one item per clock edge.
  bit           q_v[$];
  logic [W-1:0] q_d[$];
  string        q_t[$];

  localparam logic [2:0] SEL = 3'b001;   // {cs1_n, cs2_n, cs2}

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] b, input logic [1:0] c);
    return {b[AW-1:2], 2'(b[1:0] ^ c)};
  endfunction

  // Driver: apply one command at the falling edge and predict the output
  // that follows the next rising edge.
  task automatic cmd(input logic p_n, input logic c_n, input logic v_n,
                     input logic [2:0] cs, input logic g_n, input logic b_n,
                     input logic [3:0] bw, input logic o_n,
                     input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
    bit sel, wc, fromp, wr, rd;
    int kind;  // 0 idle, 1 deselect, 2 start, 3 advance, 4 hold
    logic [AW-1:0] ea;
    @(negedge clk);
    adsp_n = p_n; adsc_n = c_n; adv_n = v_n;
    {cs1_n, cs2_n, cs2} = cs;
    gw_n = g_n; bwe_n = b_n; bw_n = bw; oe_n = o_n; addr = a; din = d;
    sel   = (cs == SEL);
    wc    = !g_n || (!b_n && bw != 4'hF);
    fromp = 0;
    if (!p_n && !cs[2]) begin kind = sel ? 2 : 1; fromp = sel; end
    else if (!c_n) kind = sel ? 2 : 1;
    else if (m_act) kind = v_n ? 4 : 3;
    else kind = 0;
    if (kind == 2)      ea = a;
    else if (kind == 3) ea = step_addr(m_base, m_cnt + 2'd1);
    else                ea = step_addr(m_base, m_cnt);
    wr = wc && !fromp && kind >= 2;
    rd = !wr && (kind == 2 || kind == 3 || (kind == 4 && !m_mwr));
    q_v.push_back(m_pv && !wr);
    q_d.push_back(m_mem[m_pa]);
    q_t.push_back(tag);
    if (wr)
      for (int l = 0; l < 4; l++)
        if (!g_n || !bw[l]) m_mem[ea][l*9 +: 9] = d[l*9 +: 9];
    case (kind)
      1: m_act = 0;
      2: begin m_act = 1; m_base = a; m_cnt = 0; m_mwr = wr; end
      3: begin m_cnt = m_cnt + 2'd1; m_mwr = wr; end
      4: if (wr) m_mwr = 1;
      default: ;
    endcase
    m_pv = rd;
    m_pa = ea;
  endtask

  task automatic idle(input string tag);
    cmd(1, 1, 1, SEL, 1, 1, 4'hF, 0, '0, '0, tag);
  endtask

  // Monitor: compare drive flag and data for each predicted edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_v.size() > 0) begin
        bit ev;
        logic [W-1:0] ed;
        string tg;
        bit exp_drv;
        ev = q_v.pop_front(); ed = q_d.pop_front(); tg = q_t.pop_front();
        exp_drv = ev && !oe_n;
        chk(dq_drive == exp_drv, {tg, " drive"}, {35'd0, dq_drive}, {35'd0, exp_drv});
        if (ev) chk(dout === ed, {tg, " data"}, dout, ed);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    // R12: a read strobed under reset must not drive the bus.
    @(negedge clk);
    adsc_n = 0; {cs1_n, cs2_n, cs2} = SEL; oe_n = 0; addr = 6'd8;
    repeat (3) @(negedge clk);
    chk(dq_drive == 1'b0, "R12 reset drive", {35'd0, dq_drive}, '0);
    adsc_n = 1;
    rst = 0;

    // R4 / R8: write burst from 8 (8,9,10,11) and from 22 (22,23,20,21).
    cmd(1, 0, 1, SEL, 0, 1, 4'hF, 0, 6'd8, 36'h1_0000_0008, "R4");
    for (int i = 1; i < 4; i++)
      cmd(1, 1, 0, SEL, 0, 1, 4'hF, 0, '0, 36'h1_0000_0008 + 36'(i), "R8");
    cmd(1, 0, 1, SEL, 0, 1, 4'hF, 0, 6'd22, 36'hA_AAAA_0022, "R4");
    cmd(1, 1, 0, SEL, 0, 1, 4'hF, 0, '0, 36'hA_AAAA_0023, "R8");
    cmd(1, 1, 0, SEL, 0, 1, 4'hF, 0, '0, 36'hA_AAAA_0020, "R8");
    cmd(1, 1, 0, SEL, 0, 1, 4'hF, 0, '0, 36'hA_AAAA_0021, "R8");

    // R3: processor strobe reads even with byte writes active; R8 order, R7 hold.
    cmd(0, 1, 1, SEL, 1, 0, 4'h0, 0, 6'd20, 36'hF_FFFF_FFFF, "R3");
    for (int i = 0; i < 3; i++) cmd(1, 1, 0, SEL, 1, 1, 4'hF, 0, '0, '0, "R8");
    cmd(1, 1, 1, SEL, 1, 1, 4'hF, 0, '0, '0, "R7");
    cmd(1, 1, 1, SEL, 1, 1, 4'hF, 0, '0, '0, "R7");
    cmd(1, 1, 0, SEL, 1, 1, 4'hF, 0, '0, '0, "R8 wrap");
    idle("R9");
    idle("R9");

    // R6 / R5: lane writes and a byte-write enable with no lane is a read.
    cmd(1, 0, 1, SEL, 0, 1, 4'hF, 0, 6'd5, 36'h0_0000_0000, "R6");
    cmd(1, 0, 1, SEL, 1, 0, 4'b1010, 0, 6'd5, 36'hF_FFFF_FFFF, "R6");
    cmd(1, 0, 1, SEL, 1, 0, 4'hF, 0, 6'd5, 36'h5_5555_5555, "R5");
    idle("R6");
    cmd(1, 0, 1, SEL, 1, 0, 4'b0101, 0, 6'd5, 36'h1_2345_6789, "R6");
    cmd(1, 0, 1, SEL, 1, 0, 4'hF, 0, 6'd5, '0, "R6");
    idle("R6");
    idle("R6");

    // R3: processor-started burst written by the following hold cycle.
    cmd(0, 1, 1, SEL, 1, 1, 4'hF, 0, 6'd10, '0, "R3");
    cmd(1, 1, 1, SEL, 0, 1, 4'hF, 0, '0, 36'h3_C3C3_C3C3, "R3");
    cmd(1, 0, 1, SEL, 1, 1, 4'hF, 0, 6'd10, '0, "R3");
    idle("R3");
    idle("R3");

    // R2: processor strobe with cs1_n high acts as an advance.
    cmd(1, 0, 1, SEL, 1, 1, 4'hF, 0, 6'd8, '0, "R2");
    cmd(0, 1, 0, 3'b101, 1, 1, 4'hF, 0, 6'd30, '0, "R2");
    idle("R2");
    idle("R2");

    // R1: unselected strobed write does not reach the array.
    cmd(1, 0, 1, 3'b000, 0, 1, 4'hF, 0, 6'd8, 36'hD_EADD_EADD, "R1");
    cmd(1, 1, 0, SEL, 0, 1, 4'hF, 0, '0, 36'hD_EADD_EADD, "R1");
    cmd(0, 1, 1, 3'b011, 0, 1, 4'hF, 0, 6'd8, 36'hD_EADD_EADD, "R1");
    cmd(1, 0, 1, SEL, 1, 1, 4'hF, 0, 6'd8, '0, "R1");
    idle("R1");
    idle("R1");

    // R10: deselect in the middle of a read burst.
    cmd(1, 0, 1, SEL, 1, 1, 4'hF, 0, 6'd9, '0, "R10");
    cmd(1, 1, 0, SEL, 1, 1, 4'hF, 0, '0, '0, "R10");
    cmd(1, 0, 1, 3'b000, 1, 1, 4'hF, 0, 6'd9, '0, "R10");
    cmd(1, 1, 0, SEL, 1, 1, 4'hF, 0, '0, '0, "R10");
    idle("R10");

    // R9: output enable gates the drive without a clock.
    cmd(1, 0, 1, SEL, 1, 1, 4'hF, 1, 6'd20, '0, "R9");
    cmd(1, 1, 1, SEL, 1, 1, 4'hF, 1, '0, '0, "R9 oe high");
    cmd(1, 1, 1, SEL, 1, 1, 4'hF, 0, '0, '0, "R9 oe low");
    idle("R9");

    // R11: a write after a read silences the bus; a hold does not restart it.
    cmd(1, 0, 1, SEL, 1, 1, 4'hF, 0, 6'd21, '0, "R11");
    cmd(1, 0, 1, SEL, 0, 1, 4'hF, 0, 6'd8, 36'h1_0000_0008, "R11");
    cmd(1, 1, 1, SEL, 1, 1, 4'hF, 0, '0, '0, "R11");
    cmd(1, 1, 1, SEL, 1, 1, 4'hF, 0, '0, '0, "R11");
    cmd(1, 1, 0, SEL, 1, 1, 4'hF, 0, '0, '0, "R11");
    idle("R11");
    idle("R11");

    // R12: reset in the middle of a read clears the pipeline.
    cmd(1, 0, 1, SEL, 1, 1, 4'hF, 0, 6'd8, '0, "R12");
    @(negedge clk);
    rst = 1; adsc_n = 1; oe_n = 0;
    @(posedge clk);
    #2;
    chk(dq_drive == 1'b0, "R12 reset mid-read", {35'd0, dq_drive}, '0);
    @(negedge clk);
    chk(dq_drive == 1'b0, "R12 reset hold", {35'd0, dq_drive}, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule